// File: doc/BRIEF.md
# Wake-up Power Control

This block decides when an external system supply is switched on. It drives an active-low, open-drain power-enable line. The logic either pulls the line low or releases it. While main power is absent, two hardware events can pull the line low. One is a falling edge on a key (kickstart) input. The other is a date/time alarm match. Each event is gated by its own enable bits. Once main power is back, software owns the line and switches the supply off with a register write. While powered, the key input acts as an ordinary interrupt source. The block also combines its status flags with their interrupt enables into one active-low, open-drain interrupt request.

The core is a three-state machine:
- `PS_OFF` releases the line.
- `PS_WOKEN` holds the line low after a hardware wake, until main power returns.
- `PS_SW_ON` holds the line low under software ownership.

Its transitions are:
- **hw_wake**: `PS_OFF` to `PS_WOKEN`, on an enabled key edge or alarm match while main power is absent.
- **sw_on**: `PS_OFF` to `PS_SW_ON`, on a control write with the power bit set while main power is good.
- **power_return**: `PS_WOKEN` to `PS_SW_ON`, when main power becomes good.
- **sw_off**: `PS_SW_ON` to `PS_OFF`, on a control write with the power bit clear while main power is good.

Every other condition keeps the current state.

Register map:
- Writes with `wr_addr`=0 load the control register:
  - bit0: power on/off request
  - bit1: auxiliary-supply enable
  - bit2: key wake enable
  - bit3: alarm wake enable
  - bit4: key interrupt enable
  - bit5: alarm interrupt enable
- Writes with `wr_addr`=1 clear flags, one per written 1:
  - bit0: key flag
  - bit1: alarm flag

The flags are visible on `wake_flags`, with bit0 for the key and bit1 for the alarm.

Top module: `wake_pwr_ctl`

## Requirements
- R1: After reset, `pwr_pull_low` and `irq_pull_low` are 0, and `wake_flags` is 0.
- R2: With main power absent, `aux_present`=1 and control bits 1 and 2 set, a high-to-low change of `kick_n` makes `pwr_pull_low` 1 and sets `wake_flags[0]`, three clock edges after the change.
- R3: If any one of `aux_present`, control bit1 or control bit2 is 0, a key edge while main power is absent leaves `pwr_pull_low` at 0 and `wake_flags[0]` at 0.
- R4: With main power absent, `alarm_hit` high at a clock edge makes `pwr_pull_low` 1 and sets `wake_flags[1]` at that edge, provided control bit3 is 1. If bit3 is 0, neither changes.
- R5: A key held low produces a single event. A flag cleared while the key stays low remains clear.
- R6: With main power good, a key edge or an alarm match sets its flag (`wake_flags` bit0 or bit1) and does not change `pwr_pull_low`.
- R7: With main power good, a control write with bit0=1 makes `pwr_pull_low` 1 at the next edge. A control write with bit0=0 makes it 0 at the next edge and leaves `wake_flags` unchanged.
- R8: Register writes are ignored while `main_pwr_ok`=0.
- R9: `irq_pull_low` is 1 while any flag is set together with its interrupt enable (key flag with control bit4, alarm flag with control bit5). It returns to 0 only after every such enabled flag is cleared.
- R10: After a hardware wake, `pwr_pull_low` stays 1 when main power returns, until software writes control bit0=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_pwr_ok | input | 1 | Main supply good |
| aux_present | input | 1 | Auxiliary supply present |
| kick_n | input | 1 | Asynchronous key input, active low |
| alarm_hit | input | 1 | Date/time alarm match |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = flag clear |
| wr_data | input | 6 | Write data |
| pwr_pull_low | output | 1 | 1 = pull the power-enable line low |
| irq_pull_low | output | 1 | 1 = pull the interrupt line low |
| wake_flags | output | 2 | Sticky flags: bit0 key, bit1 alarm |

## Verification
The hardest situation to reach is a wake decision that depends on enable bits which cannot be written while main power is absent. Each case therefore first programs the control register with main power good, then drops main power, and only then fires the event.

The bench sweeps all eight combinations of auxiliary supply, auxiliary enable and key wake enable, and both alarm enable settings, restarting from reset each time. The interrupt release order is reached by raising both flags with main power present and clearing them one at a time. During this sequence the key is held low, so any repeated event would show up.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_WOKEN  = 2'd1,
        PS_SW_ON  = 2'd2
    } pwr_state_e;

    // control register bits 5..1 (bit0 is an action, not stored)
    typedef struct packed {
        logic alm_irq_en;   // bit5
        logic key_irq_en;   // bit4
        logic alm_wake_en;  // bit3
        logic key_wake_en;  // bit2
        logic aux_en;       // bit1
    } wake_ctl_t;

    localparam int CTL_W      = 6;
    localparam int FLAG_W     = 2;
    localparam int FLAG_KEY   = 0;
    localparam int FLAG_ALM   = 1;
    localparam int PWR_BIT    = 0;

endpackage

// File: rtl/wake_key_sync.sv
module wake_key_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_n,
    output logic key_fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[LAST-1:0], key_n};
    end

    assign key_fall = chain[LAST] & ~chain[LAST-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        key_fall |=> !key_fall); // R5

endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_pwr_ok,
    input  logic              aux_present,
    input  logic              key_fall,
    input  logic              alarm_hit,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CTL_W-1:0]  wr_data,
    output logic              key_wake,
    output logic              alm_wake,
    output logic              sw_on_req,
    output logic              sw_off_req,
    output logic [FLAG_W-1:0] flags,
    output logic              irq_pull_low
);
    wake_ctl_t         ctl;
    logic              wr_ctl, wr_clr;
    logic [FLAG_W-1:0] set_v, clr_v, irq_en;

    assign wr_ctl = wr_en && main_pwr_ok && (wr_addr == 1'b0);
    assign wr_clr = wr_en && main_pwr_ok && (wr_addr == 1'b1);

    assign sw_on_req  = wr_ctl &&  wr_data[PWR_BIT];
    assign sw_off_req = wr_ctl && !wr_data[PWR_BIT];

    assign key_wake = !main_pwr_ok && aux_present && ctl.aux_en
                      && ctl.key_wake_en && key_fall;
    assign alm_wake = !main_pwr_ok && ctl.alm_wake_en && alarm_hit;

    always_comb begin
        set_v           = '0;
        set_v[FLAG_KEY] = key_fall  && (main_pwr_ok || key_wake);
        set_v[FLAG_ALM] = alarm_hit && (main_pwr_ok || alm_wake);
        clr_v           = wr_clr ? wr_data[FLAG_W-1:0] : '0;
        irq_en           = '0;
        irq_en[FLAG_KEY] = ctl.key_irq_en;
        irq_en[FLAG_ALM] = ctl.alm_irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl <= '0;
        else if (wr_ctl) ctl <= wr_data[CTL_W-1:1];
    end

    genvar g;
    generate
        for (g = 0; g < FLAG_W; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        flags[g] <= 1'b0;
                else if (set_v[g]) flags[g] <= 1'b1;
                else if (clr_v[g]) flags[g] <= 1'b0;
            end
        end
    endgenerate

    assign irq_pull_low = |(flags & irq_en);

    AST_CTL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr_ok |=> $stable(ctl)); // R8
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pull_low && !wr_clr && !wr_ctl) |=> irq_pull_low); // R9
    AST_NO_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_pwr_ok && !(aux_present && ctl.aux_en && ctl.key_wake_en)
         && !flags[FLAG_KEY]) |=> !flags[FLAG_KEY]); // R3

endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic main_pwr_ok,
    input  logic hw_wake,
    input  logic sw_on_req,
    input  logic sw_off_req,
    output logic pwr_pull_low
);
    pwr_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_OFF: begin
                if (hw_wake)        state_nx = PS_WOKEN;
                else if (sw_on_req) state_nx = PS_SW_ON;
            end
            PS_WOKEN: begin
                if (main_pwr_ok)    state_nx = PS_SW_ON;
            end
            PS_SW_ON: begin
                if (sw_off_req)     state_nx = PS_OFF;
            end
            default:                state_nx = PS_OFF;
        endcase
    end

    always_comb begin
        unique case (state)
            PS_WOKEN, PS_SW_ON: pwr_pull_low = 1'b1;
            default:            pwr_pull_low = 1'b0;
        endcase
    end

    AST_WAKE_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_wake && !pwr_pull_low) |=> pwr_pull_low); // R2
    AST_ON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_pull_low && !sw_off_req) |=> pwr_pull_low); // R10
    AST_SW_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_on_req && !pwr_pull_low) |=> pwr_pull_low); // R7

endmodule

// File: rtl/wake_pwr_ctl.sv
module wake_pwr_ctl
    import wake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_pwr_ok,
    input  logic              aux_present,
    input  logic              kick_n,
    input  logic              alarm_hit,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CTL_W-1:0]  wr_data,
    output logic              pwr_pull_low,
    output logic              irq_pull_low,
    output logic [FLAG_W-1:0] wake_flags
);
    logic key_fall, key_wake, alm_wake, sw_on_req, sw_off_req;

    wake_key_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .key_n(kick_n), .key_fall(key_fall)
    );

    wake_regs u_regs (
        .clk(clk), .rst_n(rst_n), .main_pwr_ok(main_pwr_ok),
        .aux_present(aux_present), .key_fall(key_fall), .alarm_hit(alarm_hit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .key_wake(key_wake), .alm_wake(alm_wake),
        .sw_on_req(sw_on_req), .sw_off_req(sw_off_req),
        .flags(wake_flags), .irq_pull_low(irq_pull_low)
    );

    wake_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .main_pwr_ok(main_pwr_ok),
        .hw_wake(key_wake || alm_wake),
        .sw_on_req(sw_on_req), .sw_off_req(sw_off_req),
        .pwr_pull_low(pwr_pull_low)
    );

    AST_POWERED_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (main_pwr_ok && !pwr_pull_low && !(wr_en && !wr_addr)) |=> !pwr_pull_low); // R6

endmodule

// File: tb/wake_pwr_ctl_bench.sv
module wake_pwr_ctl_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       main_pwr_ok = 0, aux_present = 0, kick_n = 1, alarm_hit = 0;
    logic       wr_en = 0, wr_addr = 0;
    logic [5:0] wr_data = 0;
    logic       pwr_pull_low, irq_pull_low;
    logic [1:0] wake_flags;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wake_pwr_ctl u_wake_pwr_ctl (
        .clk(clk), .rst_n(rst_n), .main_pwr_ok(main_pwr_ok),
        .aux_present(aux_present), .kick_n(kick_n), .alarm_hit(alarm_hit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwr_pull_low(pwr_pull_low), .irq_pull_low(irq_pull_low),
        .wake_flags(wake_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; main_pwr_ok = 0; aux_present = 0;
        kick_n = 1; alarm_hit = 0; wr_en = 0;
        cyc(2); rst_n = 1; cyc(1);
    endtask

    task automatic wr(input logic a, input logic [5:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    initial begin
        do_reset();
        chk("R1 pwr", pwr_pull_low, 0);
        chk("R1 irq", irq_pull_low, 0);
        chk("R1 flags", wake_flags, 0);

        // R2/R3 sweep: aux_present, aux_en (bit1), key_wake_en (bit2)
        for (int i = 0; i < 8; i++) begin
            int e;
            do_reset();
            main_pwr_ok = 1;
            wr(0, {3'b000, i[1], i[0], 1'b0});
            main_pwr_ok = 0; aux_present = i[2];
            kick_n = 0; cyc(3);
            e = (i == 7) ? 1 : 0;
            chk(e ? "R2 pwr" : "R3 pwr", pwr_pull_low, e);
            chk(e ? "R2 flag" : "R3 flag", wake_flags[0], e);
            kick_n = 1; cyc(3);
        end

        // R4 sweep over alarm wake enable (bit3), then R10 and R7
        for (int j = 0; j < 2; j++) begin
            do_reset();
            main_pwr_ok = 1;
            wr(0, {2'b00, j[0], 3'b000});
            main_pwr_ok = 0;
            alarm_hit = 1; @(negedge clk); alarm_hit = 0;
            chk("R4 pwr", pwr_pull_low, j);
            chk("R4 flag", wake_flags[1], j);
            if (j == 1) begin
                main_pwr_ok = 1; cyc(3);
                chk("R10 held after power return", pwr_pull_low, 1);
                wr(0, 6'b001000);
                chk("R7 sw off", pwr_pull_low, 0);
                chk("R7 flags kept", wake_flags, 2);
            end
        end

        // R7 / R8 software control
        do_reset();
        main_pwr_ok = 1;
        wr(0, 6'b000001);
        chk("R7 sw on", pwr_pull_low, 1);
        main_pwr_ok = 0;
        wr(0, 6'b000000); cyc(1);
        chk("R8 write ignored", pwr_pull_low, 1);
        main_pwr_ok = 1;
        wr(0, 6'b000000);
        chk("R7 sw off", pwr_pull_low, 0);

        // R6 / R9 / R5 interrupts with main power good
        do_reset();
        main_pwr_ok = 1;
        wr(0, 6'b110000);
        kick_n = 0; cyc(3);
        chk("R6 key flag", wake_flags[0], 1);
        chk("R6 pwr unchanged", pwr_pull_low, 0);
        chk("R9 irq key", irq_pull_low, 1);
        alarm_hit = 1; @(negedge clk); alarm_hit = 0;
        chk("R6 alarm flag", wake_flags[1], 1);
        chk("R6 pwr unchanged alarm", pwr_pull_low, 0);
        wr(1, 6'b000001);
        chk("R9 irq held by alarm", irq_pull_low, 1);
        chk("R9 key cleared", wake_flags[0], 0);
        wr(1, 6'b000010);
        chk("R9 irq released", irq_pull_low, 0);
        cyc(5);
        chk("R5 held key single event", wake_flags[0], 0);
        kick_n = 1; cyc(3);
        // flag set with interrupt disabled: no request
        wr(0, 6'b000000);
        kick_n = 0; cyc(3);
        chk("R9 disabled flag", wake_flags[0], 1);
        chk("R9 disabled irq", irq_pull_low, 0);
        // R8: writes while main absent do not enable interrupts
        main_pwr_ok = 0;
        wr(0, 6'b010000); cyc(1);
        chk("R8 irq stays off", irq_pull_low, 0);
        kick_n = 1;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule